// File: doc/BRIEF.md
# Reset-Strap Mode Decoder and Port Power-Disable Encoder

This block sits in the configuration logic of a three-port serial-bus physical layer. While the hardware reset is held, it watches two strap pins: a link-clock strap and a mode-select strap. On the clock edge where the internal reset releases, it keeps the operating mode they select. That mode then stays fixed until the next reset. The mode says whether a link controller is fitted and, if one is, which generation it is.

With no link controller fitted, nothing uses the 8-bit data bus for link traffic. In that mode the block drives the bus with one cable-power disable flag per port, plus a flag that is set only when all three ports want power removed. Each port's flag comes from that port's status inputs: disable bits, connection state, sleep state, DS-mode connection and activity. In either link mode the bus passes the link data path through, one cycle late.

Top module: `strap_power_indicator`

## Requirements
- R1: The mode output reads 2'b10 (no link fitted) when the link-clock strap is high. It reads 2'b00 (legacy link) when that strap is low and mode-select is low, and 2'b01 (newer link) when that strap is low and mode-select is high.
- R2: The mode is captured from the straps as the internal reset releases, two clock cycles after the hardware reset input rises. After that it does not change, whatever the straps do, until the next hardware reset.
- R3: While the hardware reset input is low, the data bus reads all zeros, and it clears as soon as the reset asserts.
- R4: In no-link mode, data bit k (k = 0, 1, 2) carries the disable flag of port k, registered one clock after the port status inputs.
- R5: A port's flag is set when the port is not connected, or when it is asleep. It is also set when its disabled bit is set together with the hard-disable bit or the sleep-enable bit, or when it is connected in DS mode but not active.
- R6: A port's flag is clear when the port is connected and awake, is not disabled together with hard-disable or sleep-enable, and is either not in DS mode or active.
- R7: In no-link mode, data bit 6 is the AND of data bits 0, 1 and 2.
- R8: In no-link mode, data bits 3, 4, 5 and 7 read 0.
- R9: In legacy or newer-link mode, the data bus equals the link data input, registered one clock later, and the port status inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Hardware reset, active low; asserts at once and releases in step with the clock |
| lclk_strap_i | input | 1 | Link-clock strap; high selects no-link mode |
| mode_sel_strap_i | input | 1 | Link-generation strap; 0 selects legacy, 1 selects newer |
| port_disabled_i | input | 3 | Per-port disabled bit |
| port_hard_dis_i | input | 3 | Per-port hard-disable bit |
| port_sleep_en_i | input | 3 | Per-port sleep-enable bit |
| port_connected_i | input | 3 | Per-port dc-connected status |
| port_asleep_i | input | 3 | Per-port asleep status |
| port_ds_i | input | 3 | Per-port connected-in-DS-mode status |
| port_active_i | input | 3 | Per-port active status |
| link_data_i | input | 8 | Data from the link interface path |
| mode_o | output | 2 | Mode captured at reset (encoding as in R1) |
| data_o | output | 8 | Data bus: power flags or link data |

## Verification
The hardest case to reach is a change on the straps after reset, because the mode must ignore it. The bench latches each of the four strap combinations in turn. It then swaps both straps to the opposite values, waits longer than the synchronizer delay, and confirms that the mode output has not moved. To show that the status inputs are ignored in the link modes, it drives them with patterns that would set every flag while it sweeps the link data.

// File: rtl/strap_power_pkg.sv
package strap_power_pkg;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_NEWER  = 2'b01,
    MODE_NOLINK = 2'b10
  } link_mode_e;

  function automatic link_mode_e decode_straps(input logic lclk_s, input logic sel_s);
    if (lclk_s)     return MODE_NOLINK;
    else if (sel_s) return MODE_NEWER;
    else            return MODE_LEGACY;
  endfunction

endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/sp_strap_capture.sv
module sp_strap_capture
  import strap_power_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_int_n,
  input  logic       lclk_strap_i,
  input  logic       mode_sel_strap_i,
  output link_mode_e mode_o
);
  logic [SYNC_STAGES-1:0] lclk_sync_q;
  logic [SYNC_STAGES-1:0] sel_sync_q;
  link_mode_e             mode_q;
  link_mode_e             mode_d;
  logic                   capture_en;

  // Synchronizer chains run freely; they hold no reset state.
  always_ff @(posedge clk) begin
    lclk_sync_q <= {lclk_sync_q[SYNC_STAGES-2:0], lclk_strap_i};
    sel_sync_q  <= {sel_sync_q[SYNC_STAGES-2:0], mode_sel_strap_i};
  end

  // Capture is open for as long as the internal reset is held, so the last
  // load happens on the edge where that reset releases.
  assign capture_en = !rst_int_n;

  always_comb begin
    mode_d = mode_q;
    if (capture_en)
      mode_d = decode_straps(lclk_sync_q[SYNC_STAGES-1], sel_sync_q[SYNC_STAGES-1]);
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/sp_port_flag.sv
module sp_port_flag (
  input  logic disabled_i,
  input  logic hard_dis_i,
  input  logic sleep_en_i,
  input  logic connected_i,
  input  logic asleep_i,
  input  logic ds_i,
  input  logic active_i,
  output logic power_off_o
);
  logic forced_off;
  logic link_down;
  logic ds_idle;

  always_comb begin
    forced_off  = disabled_i & (hard_dis_i | sleep_en_i);
    link_down   = !connected_i | asleep_i;
    ds_idle     = ds_i & !active_i;
    power_off_o = forced_off | link_down | ds_idle;
  end
endmodule

// File: rtl/strap_power_indicator.sv
module strap_power_indicator
  import strap_power_pkg::*;
#(
  parameter int NPORTS      = 3,
  parameter int DW          = 8,
  parameter int ALL_BIT     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              lclk_strap_i,
  input  logic              mode_sel_strap_i,
  input  logic [NPORTS-1:0] port_disabled_i,
  input  logic [NPORTS-1:0] port_hard_dis_i,
  input  logic [NPORTS-1:0] port_sleep_en_i,
  input  logic [NPORTS-1:0] port_connected_i,
  input  logic [NPORTS-1:0] port_asleep_i,
  input  logic [NPORTS-1:0] port_ds_i,
  input  logic [NPORTS-1:0] port_active_i,
  input  logic [DW-1:0]     link_data_i,
  output logic [1:0]        mode_o,
  output logic [DW-1:0]     data_o
);
  localparam int RSV_LO = NPORTS;

  logic              rst_int_n;
  link_mode_e        mode;
  logic [NPORTS-1:0] port_off;
  logic [DW-1:0]     flag_bus;
  logic [DW-1:0]     data_d;
  logic [DW-1:0]     data_q;

  sp_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (hw_rst_n),
    .rst_n_o(rst_int_n)
  );

  sp_strap_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk             (clk),
    .rst_int_n       (rst_int_n),
    .lclk_strap_i    (lclk_strap_i),
    .mode_sel_strap_i(mode_sel_strap_i),
    .mode_o          (mode)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    sp_port_flag u_flag (
      .disabled_i (port_disabled_i[p]),
      .hard_dis_i (port_hard_dis_i[p]),
      .sleep_en_i (port_sleep_en_i[p]),
      .connected_i(port_connected_i[p]),
      .asleep_i   (port_asleep_i[p]),
      .ds_i       (port_ds_i[p]),
      .active_i   (port_active_i[p]),
      .power_off_o(port_off[p])
    );
  end

  // Bus layout: one flag per port from bit 0 up, the all-ports bit, zeros elsewhere.
  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b < RSV_LO) begin : g_flag
      assign flag_bus[b] = port_off[b];
    end else if (b == ALL_BIT) begin : g_all
      assign flag_bus[b] = &port_off;
    end else begin : g_rsv
      assign flag_bus[b] = 1'b0;
    end
  end

  always_comb begin
    data_d = (mode == MODE_NOLINK) ? flag_bus : link_data_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) data_q <= '0;
    else            data_q <= data_d;
  end

  assign mode_o = mode;
  assign data_o = data_q;
endmodule

// File: rtl/strap_power_chk.sv
module strap_power_chk #(
  parameter int NPORTS = 3,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [1:0]        mode_o,
  input logic [DW-1:0]     data_o,
  input logic [NPORTS-1:0] port_disabled_i,
  input logic [NPORTS-1:0] port_hard_dis_i,
  input logic [NPORTS-1:0] port_sleep_en_i,
  input logic [NPORTS-1:0] port_connected_i,
  input logic [NPORTS-1:0] port_asleep_i,
  input logic [NPORTS-1:0] port_ds_i,
  input logic [NPORTS-1:0] port_active_i,
  input logic [DW-1:0]     link_data_i
);
  logic [NPORTS-1:0] exp_off;
  always_comb begin
    for (int p = 0; p < NPORTS; p++)
      exp_off[p] = (port_disabled_i[p] && (port_hard_dis_i[p] || port_sleep_en_i[p]))
                   || !port_connected_i[p] || port_asleep_i[p]
                   || (port_ds_i[p] && !port_active_i[p]);
  end

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(rst_int_n) |-> $stable(mode_o));

  p_flags_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_o == 2'b10) |=> (data_o[NPORTS-1:0] == $past(exp_off)));

  p_all_and_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_o == 2'b10) |-> (data_o[6] == (data_o[0] & data_o[1] & data_o[2])));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_o == 2'b10) |-> (data_o[5:3] == 3'b000 && data_o[7] == 1'b0));

  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_o != 2'b10) |=> (data_o == $past(link_data_i)));
endmodule

bind strap_power_indicator strap_power_chk #(.NPORTS(NPORTS), .DW(DW)) u_chk (
  .clk             (clk),
  .rst_int_n       (rst_int_n),
  .mode_o          (mode_o),
  .data_o          (data_o),
  .port_disabled_i (port_disabled_i),
  .port_hard_dis_i (port_hard_dis_i),
  .port_sleep_en_i (port_sleep_en_i),
  .port_connected_i(port_connected_i),
  .port_asleep_i   (port_asleep_i),
  .port_ds_i       (port_ds_i),
  .port_active_i   (port_active_i),
  .link_data_i     (link_data_i)
);

// File: tb/test_strap_power_indicator.sv
module test_strap_power_indicator;
  logic       clk = 1'b0;
  logic       hw_rst_n = 1'b0;
  logic       lclk_s = 1'b0, sel_s = 1'b0;
  logic [2:0] dis = '0, hdis = '0, slp = '0, conn = '0, aslp = '0, ds = '0, act = '0;
  logic [7:0] ldata = '0;
  logic [1:0] mode;
  logic [7:0] data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  strap_power_indicator i_strap_power_indicator (
    .clk(clk), .hw_rst_n(hw_rst_n), .lclk_strap_i(lclk_s), .mode_sel_strap_i(sel_s),
    .port_disabled_i(dis), .port_hard_dis_i(hdis), .port_sleep_en_i(slp),
    .port_connected_i(conn), .port_asleep_i(aslp), .port_ds_i(ds), .port_active_i(act),
    .link_data_i(ldata), .mode_o(mode), .data_o(data)
  );

  task automatic check(input string req, input logic [7:0] act_v, input logic [7:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  // Pattern bits: 0 disabled, 1 hard-dis, 2 sleep-en, 3 connected, 4 asleep, 5 ds, 6 active
  function automatic logic exp_flag(input logic [6:0] v);
    return (v[0] & (v[1] | v[2])) | !v[3] | v[4] | (v[5] & !v[6]);
  endfunction

  task automatic set_port(input int p, input logic [6:0] v);
    dis[p] = v[0]; hdis[p] = v[1]; slp[p] = v[2]; conn[p] = v[3];
    aslp[p] = v[4]; ds[p] = v[5]; act[p] = v[6];
  endtask

  task automatic reset_with(input logic l, input logic s);
    @(negedge clk);
    hw_rst_n = 1'b0;
    lclk_s = l; sel_s = s;
    ldata = 8'hA5;
    set_port(0, 7'h00); set_port(1, 7'h00); set_port(2, 7'h00);
    #1 check("R3 reset clears bus", data, 8'h00);
    repeat (5) @(negedge clk);
    check("R3 bus zero during reset", data, 8'h00);
    hw_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 and R2: each strap pair, then flip the straps after capture
    for (int c = 0; c < 4; c++) begin
      logic l, s;
      logic [1:0] em;
      l = c[1]; s = c[0];
      em = l ? 2'b10 : (s ? 2'b01 : 2'b00);
      reset_with(l, s);
      check("R1 mode decode", {6'b0, mode}, {6'b0, em});
      lclk_s = ~l; sel_s = ~s;
      repeat (6) @(negedge clk);
      check("R2 mode held after strap change", {6'b0, mode}, {6'b0, em});
    end

    // R9: link modes pass data through; status set to force every flag
    for (int m = 0; m < 2; m++) begin
      reset_with(1'b0, m[0]);
      set_port(0, 7'h00); set_port(1, 7'h10); set_port(2, 7'h03);
      for (int v = 0; v < 32; v++) begin
        ldata = 8'((v * 53 + 7) & 255);
        @(negedge clk);
        check("R9 pass-through", data, ldata);
      end
    end

    // R4-R8: no-link mode, every status pattern on every port
    reset_with(1'b1, 1'b0);
    check("R1 no-link latched", {6'b0, mode}, 8'h02);
    for (int v = 0; v < 128; v++) begin
      logic [6:0] p0, p1, p2;
      logic [2:0] f;
      p0 = 7'(v); p1 = 7'((v * 37 + 5) & 127); p2 = 7'((v * 91 + 11) & 127);
      set_port(0, p0); set_port(1, p1); set_port(2, p2);
      ldata = 8'(v);
      f = {exp_flag(p2), exp_flag(p1), exp_flag(p0)};
      @(negedge clk);
      check("R4 R5 R6 port flags", {5'b0, data[2:0]}, {5'b0, f});
      check("R7 all-ports bit", {7'b0, data[6]}, {7'b0, &f});
      check("R8 reserved bits", {data[7], data[5:3]}, 4'b0);
    end
    // R6 explicit clear: connected, awake, active DS, disabled without hard/sleep
    set_port(0, 7'h69); set_port(1, 7'h08); set_port(2, 7'h48);
    @(negedge clk);
    check("R6 all flags clear", data, 8'h00);
    // R5 each set condition alone on port 0
    set_port(1, 7'h08); set_port(2, 7'h08);
    set_port(0, 7'h0B); @(negedge clk); check("R5 disabled+hard", data, 8'h01);
    set_port(0, 7'h0D); @(negedge clk); check("R5 disabled+sleep-en", data, 8'h01);
    set_port(0, 7'h00); @(negedge clk); check("R5 disconnected", data, 8'h01);
    set_port(0, 7'h18); @(negedge clk); check("R5 asleep", data, 8'h01);
    set_port(0, 7'h28); @(negedge clk); check("R5 ds not active", data, 8'h01);
    set_port(1, 7'h00); set_port(2, 7'h00);
    @(negedge clk); check("R7 all off", data, 8'h47);
    // R3: reset mid-operation clears bus at once
    hw_rst_n = 1'b0; #1 check("R3 async clear", data, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule